// File: doc/BRIEF.md
# Sequenced Write-Unlock Guard

This block protects three safety-relevant control registers (watchdog control, supply-voltage detect control and clock-source control) against stray writes from a simple register write bus. The protected registers can be written only while a short window is open. Software opens that window by writing a two-bit key field, which sits in the low bits of an ordinary host control register, in a strict two-step order on consecutive cycles.

After the second key write, the window stays open for a fixed number of cycles. It closes early as soon as one protected write has been accepted, and it closes on its own when the count runs out. The key bits are write-only and always read back as zero. The upper bits of the host register are plain storage.

The bus uses one cycle per write. A write is presented on `wr_en`, `wr_addr` and `wr_data` and takes effect at the rising clock edge. Reads are combinational from `rd_addr` to `rd_data`. Addresses: host register 0, watchdog control 1, voltage-detect control 2, clock-source control 3.

Top module: `seq_unlock_guard`

## Requirements
- R1: After reset the lock is closed. The host register reads 0x00, watchdog control reads 0x01, voltage-detect control reads 0x05 and clock-source control reads 0x00.
- R2: Bits [1:0] of the host register (the key field) always read as 0. Bits [7:2] store and return whatever was last written to the host register.
- R3: The lock opens when two host register writes occur on back-to-back cycles. The first has key field 2'b10 and the second has key field 2'b11. A protected write made in the window after that is stored.
- R4: The second key write must come on the very next cycle after the first. If any cycle lies between them, the lock stays closed and a later protected write is ignored.
- R5: A single host write with key field 2'b11, made while the lock is idle, does not open the lock.
- R6: After the second key write, a protected write is accepted in any of the next WINDOW cycles (WINDOW = 3 by default). A protected write in the cycle after those is ignored, because the lock closes by itself.
- R7: A key write that breaks the order resets the sequence to idle, so the next step needs key 2'b10 again. This covers key 2'b01 while idle, and any value other than 2'b11 after the first key.
- R8: While the lock is closed, writes to the three protected registers are ignored and their values stay unchanged.
- R9: An accepted protected write closes the lock at once. A second protected write in the same window is ignored.
- R10: Bits [7:2] of a key write do not affect the sequence. Only bits [1:0] are decoded.
- R11: While the window is open, host register writes do not change the lock state, whatever their key field. A protected write later in the window is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write address (0 host, 1 watchdog, 2 voltage detect, 3 clock source) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data, with the key field masked to zero |
| wdt_ctrl | output | 8 | Watchdog control register value |
| vdet_ctrl | output | 8 | Voltage-detect control register value |
| clk_ctrl | output | 8 | Clock-source control register value |

## Verification
The bench builds the guard with its default parameters: an 8-bit data path, a 2-bit address and a three-cycle window. With these values every cycle offset inside the window can be reached, and so can the first cycle past it. This shows the exact point where the lock closes itself, and each probe needs only a few bus cycles. The fixed addresses also let one bench exercise all three protected registers. The bench covers the ways a key sequence can be broken (out of order, too slow, both bits at once), as well as one-write-per-opening and key writes made inside an open window.

// File: rtl/sug_pkg.sv
// Package: shared types and fixed key encodings for the sequenced write-unlock guard.
// Assumes: the key field is two bits wide and sits in the low bits of the host register.
package sug_pkg;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ARMED = 2'd1,
        LK_OPEN  = 2'd2
    } lock_state_t;

    localparam int unsigned KEY_W      = 2;
    localparam logic [1:0]  KEY_FIRST  = 2'b10;
    localparam logic [1:0]  KEY_SECOND = 2'b11;

endpackage

// File: rtl/sug_lock_fsm.sv
// Module: lock sequencer and window timer.
// Walks idle -> armed -> open on the two-step key sequence, then counts the window down.
// Assumes: key_wr is high for one cycle per host register write; prot_done marks an
// accepted protected write, which closes the window at once.
module sug_lock_fsm
    import sug_pkg::*;
#(
    parameter int unsigned WINDOW = 3,
    localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_bits,
    input  logic             prot_done,
    output logic             win_open,
    output lock_state_t      state_o,
    output logic [CNT_W-1:0] cnt_o
);

    lock_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and counter logic for the key sequence and the window.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LK_IDLE: begin
                if (key_wr && key_bits == KEY_FIRST) state_d = LK_ARMED;
            end
            LK_ARMED: begin
                if (key_wr && key_bits == KEY_SECOND) begin
                    state_d = LK_OPEN;
                    cnt_d   = CNT_W'(WINDOW);
                end else begin
                    state_d = LK_IDLE;
                end
            end
            LK_OPEN: begin
                if (prot_done || cnt_q <= CNT_W'(1)) begin
                    state_d = LK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = LK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign win_open = (state_q == LK_OPEN);
    assign state_o  = state_q;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/sug_write_gate.sv
// Module: address decode and write gating.
// Passes host register writes through and lets protected writes pass only while the window is open.
// Assumes: protected registers occupy NUM_PROT consecutive addresses from PROT_BASE.
module sug_write_gate #(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned NUM_PROT  = 3,
    parameter int unsigned HOST_ADDR = 0,
    parameter int unsigned PROT_BASE = 1
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                win_open,
    output logic                host_we,
    output logic [NUM_PROT-1:0] prot_we,
    output logic                prot_done
);

    assign host_we = wr_en && (wr_addr == ADDR_W'(HOST_ADDR));

    // One gated enable per protected register.
    for (genvar gi = 0; gi < NUM_PROT; gi++) begin : g_gate
        assign prot_we[gi] = wr_en && win_open && (wr_addr == ADDR_W'(PROT_BASE + gi));
    end

    assign prot_done = |prot_we;

endmodule

// File: rtl/sug_reg_bank.sv
// Module: host register, protected registers and masked readback.
// The host register stores only the bits above the key field. The key field always reads as zero.
// Assumes: PROT_RST packs the reset values, with register 0 in the lowest DATA_W bits.
module sug_reg_bank
    import sug_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned NUM_PROT  = 3,
    parameter int unsigned HOST_ADDR = 0,
    parameter int unsigned PROT_BASE = 1,
    parameter logic [NUM_PROT*DATA_W-1:0] PROT_RST = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [NUM_PROT-1:0]        prot_we,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_PROT*DATA_W-1:0] prot_q
);

    localparam int unsigned UP_W = DATA_W - KEY_W;

    logic [UP_W-1:0] host_up_q;

    // Upper host register bits behave as plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_up_q <= '0;
        else if (host_we) host_up_q <= wr_data[DATA_W-1:KEY_W];
    end

    // One register per protected control, each loading its own reset value.
    for (genvar gi = 0; gi < NUM_PROT; gi++) begin : g_prot
        always_ff @(posedge clk) begin
            if (!rst_n)          prot_q[gi*DATA_W +: DATA_W] <= PROT_RST[gi*DATA_W +: DATA_W];
            else if (prot_we[gi]) prot_q[gi*DATA_W +: DATA_W] <= wr_data;
        end
    end

    // Readback mux with the key field forced to zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(HOST_ADDR)) rd_data = {host_up_q, {KEY_W{1'b0}}};
        for (int i = 0; i < NUM_PROT; i++) begin
            if (rd_addr == ADDR_W'(PROT_BASE + i)) rd_data = prot_q[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/seq_unlock_guard.sv
// Module: top of the sequenced write-unlock guard.
// Joins the lock sequencer, the write gate and the register bank for three protected controls.
// Assumes: single-cycle bus writes, combinational reads, synchronous active-low reset.
module seq_unlock_guard
    import sug_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned WINDOW    = 3,
    parameter int unsigned HOST_ADDR = 0,
    parameter int unsigned PROT_BASE = 1,
    parameter logic [DATA_W-1:0] WDT_RST  = 8'h01,
    parameter logic [DATA_W-1:0] VDET_RST = 8'h05,
    parameter logic [DATA_W-1:0] CLK_RST  = 8'h00,
    localparam int unsigned NUM_PROT = 3,
    localparam int unsigned CNT_W    = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wdt_ctrl,
    output logic [DATA_W-1:0] vdet_ctrl,
    output logic [DATA_W-1:0] clk_ctrl
);

    logic                       host_we;
    logic [NUM_PROT-1:0]        prot_we;
    logic                       prot_done;
    logic                       win_open;
    lock_state_t                lk_state;
    logic [CNT_W-1:0]           lk_cnt;
    logic [NUM_PROT*DATA_W-1:0] prot_q;

    sug_write_gate #(
        .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
        .HOST_ADDR(HOST_ADDR), .PROT_BASE(PROT_BASE)
    ) u_gate (
        .wr_en(wr_en), .wr_addr(wr_addr), .win_open(win_open),
        .host_we(host_we), .prot_we(prot_we), .prot_done(prot_done)
    );

    sug_lock_fsm #(.WINDOW(WINDOW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .key_wr(host_we),
        .key_bits(wr_data[KEY_W-1:0]), .prot_done(prot_done),
        .win_open(win_open), .state_o(lk_state), .cnt_o(lk_cnt)
    );

    sug_reg_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
        .HOST_ADDR(HOST_ADDR), .PROT_BASE(PROT_BASE),
        .PROT_RST({CLK_RST, VDET_RST, WDT_RST})
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .prot_we(prot_we),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .prot_q(prot_q)
    );

    assign wdt_ctrl  = prot_q[0*DATA_W +: DATA_W];
    assign vdet_ctrl = prot_q[1*DATA_W +: DATA_W];
    assign clk_ctrl  = prot_q[2*DATA_W +: DATA_W];

endmodule

// File: rtl/sug_guard_checker.sv
// Module: property checker for seq_unlock_guard, attached with bind.
// Assumes: it observes the lock state and counter of the top instance.
module sug_guard_checker
    import sug_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned WINDOW    = 3,
    parameter int unsigned HOST_ADDR = 0,
    parameter int unsigned CNT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] wdt_ctrl,
    input logic [DATA_W-1:0] vdet_ctrl,
    input logic [DATA_W-1:0] clk_ctrl,
    input lock_state_t       state,
    input logic [CNT_W-1:0]  cnt
);

    logic host_wr;
    assign host_wr = wr_en && (wr_addr == ADDR_W'(HOST_ADDR));

    // R2: the key field never shows on the host readback.
    a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(HOST_ADDR)) |-> (rd_data[KEY_W-1:0] == '0));

    // R3: the open state is entered only from armed.
    a_r3_open_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_OPEN && $past(state) != LK_OPEN) |-> ($past(state) == LK_ARMED));

    // R3: the correct second key opens a full window.
    a_r3_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_ARMED && host_wr && wr_data[KEY_W-1:0] == KEY_SECOND)
        |=> (state == LK_OPEN && cnt == CNT_W'(WINDOW)));

    // R4: armed lasts one cycle only.
    a_r4_armed_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_ARMED) |=> (state != LK_ARMED));

    // R6: the window counter stays within range and is non-zero while open.
    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_W'(WINDOW)) && ((state != LK_OPEN) || (cnt != '0)));

    // R8: protected registers hold while the lock is not open.
    a_r8_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LK_OPEN) |=> ($stable(wdt_ctrl) && $stable(vdet_ctrl) && $stable(clk_ctrl)));

    // R9: an accepted protected write closes the lock.
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_OPEN && wr_en && wr_addr != ADDR_W'(HOST_ADDR)) |=> (state == LK_IDLE));

endmodule

bind seq_unlock_guard sug_guard_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW(WINDOW),
    .HOST_ADDR(HOST_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_ctrl(wdt_ctrl), .vdet_ctrl(vdet_ctrl),
    .clk_ctrl(clk_ctrl), .state(lk_state), .cnt(lk_cnt)
);

// File: tb/seq_unlock_guard_bench.sv
// Bench: scoreboard for seq_unlock_guard.
// Driver tasks push expected readback items into a queue. A monitor pops and compares them.
module seq_unlock_guard_bench;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 2;
    localparam logic [AW-1:0] A_HOST = 2'd0;
    localparam logic [AW-1:0] A_WDT  = 2'd1;
    localparam logic [AW-1:0] A_VDET = 2'd2;
    localparam logic [AW-1:0] A_CLK  = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data, wdt_ctrl, vdet_ctrl, clk_ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    seq_unlock_guard u_seq_unlock_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdt_ctrl(wdt_ctrl),
        .vdet_ctrl(vdet_ctrl), .clk_ctrl(clk_ctrl)
    );

    // Monitor: compares the readback 1 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                             it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic unlock();
        wr(A_HOST, 8'h02);
        wr(A_HOST, 8'h03);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver: stimulus sequence with expected values.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        expect_rd(A_HOST, 8'h00, "R1 host");
        expect_rd(A_WDT,  8'h01, "R1 wdt");
        expect_rd(A_VDET, 8'h05, "R1 vdet");
        expect_rd(A_CLK,  8'h00, "R1 clk");

        // R2: key bits mask, upper bits store
        wr(A_HOST, 8'hFC);  // key 00, no effect on the lock
        expect_rd(A_HOST, 8'hFC, "R2 upper");
        wr(A_HOST, 8'h00);
        wr(A_HOST, 8'h01);  // key 01 out of order, stays idle
        expect_rd(A_HOST, 8'h00, "R2 key masked");

        // R3: correct sequence opens, write lands
        unlock();
        wr(A_WDT, 8'h5A);
        expect_rd(A_WDT, 8'h5A, "R3 wdt written");

        // R4: gap between keys
        wr(A_HOST, 8'h02); idle(1); wr(A_HOST, 8'h03);
        wr(A_VDET, 8'h77);
        expect_rd(A_VDET, 8'h05, "R4 gap keeps lock closed");

        // R5: both bits at once
        idle(2);
        wr(A_HOST, 8'h03);
        wr(A_CLK, 8'h44);
        expect_rd(A_CLK, 8'h00, "R5 both bits no open");

        // R6: last cycle of the window accepted
        idle(2);
        unlock(); idle(2);
        wr(A_CLK, 8'h11);
        expect_rd(A_CLK, 8'h11, "R6 last window cycle");

        // R6: first cycle past the window ignored
        unlock(); idle(3);
        wr(A_VDET, 8'h22);
        expect_rd(A_VDET, 8'h05, "R6 past window");

        // R7: 01 then 11 does not open
        wr(A_HOST, 8'h01); wr(A_HOST, 8'h03);
        wr(A_WDT, 8'h99);
        expect_rd(A_WDT, 8'h5A, "R7 wrong first key");

        // R7: 10, 01, 11 does not open
        idle(2);
        wr(A_HOST, 8'h02); wr(A_HOST, 8'h01); wr(A_HOST, 8'h03);
        wr(A_WDT, 8'h98);
        expect_rd(A_WDT, 8'h5A, "R7 broken order");

        // R9: one write per opening
        idle(2);
        unlock();
        wr(A_WDT, 8'h33);
        wr(A_VDET, 8'h66);
        expect_rd(A_WDT,  8'h33, "R9 first write");
        expect_rd(A_VDET, 8'h05, "R9 second write ignored");

        // R10: upper bits in key writes are ignored by the sequence
        wr(A_HOST, 8'hFE); wr(A_HOST, 8'hAB);
        wr(A_VDET, 8'h3C);
        expect_rd(A_VDET, 8'h3C, "R10 upper bits ignored");
        expect_rd(A_HOST, 8'hA8, "R10 R2 host readback");

        // R11: key writes inside the window do not disturb it
        unlock();
        wr(A_HOST, 8'h06);
        wr(A_CLK, 8'h7E);
        expect_rd(A_CLK, 8'h7E, "R11 window kept");
        expect_rd(A_HOST, 8'h04, "R11 host upper");

        // R8: plain write while closed
        wr(A_WDT, 8'hEE);
        wr(A_CLK, 8'hEE);
        expect_rd(A_WDT, 8'h33, "R8 wdt closed");
        expect_rd(A_CLK, 8'h7E, "R8 clk closed");

        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule